// File: doc/BRIEF.md
# Fractional Clock Prescaler

The block divides its system clock by a programmable ratio made of a whole part M and a fractional part N counted in eighths, so the ratio is M + N/8. It emits a clock-enable strobe, high for exactly one system-clock cycle per output period. A downstream baud generator counts these strobes instead of raw clock cycles.

A ratio with a fractional part cannot be met by a single period length. The block therefore alternates between periods of M and M+1 cycles. A three-bit fractional accumulator adds N once per period. Each carry out of the accumulator adds one cycle to the period that starts next. Over eight periods the lengths add up to exactly 8M + N cycles.

The configuration word is sampled only at a period boundary, so reprogramming never produces a shortened or stretched period. A whole part of zero is treated as a ratio of one. After reset the ratio is exactly four.

Top module: `frac_prescaler`

## Requirements
- R1: `cfg_i[7:3]` holds the unsigned whole part M and `cfg_i[2:0]` holds the eighths N. The division ratio is M + N/8.
- R2: `tick_o` is high for one cycle at the end of each output period. Each period lasts M or M+1 cycles, and lasts exactly M cycles whenever N is 0.
- R3: While the configuration is held constant, any 8 consecutive output periods span 8M + N cycles in total.
- R4: When M is 0, the ratio is treated as 1 and N is ignored, so `tick_o` is high on every cycle.
- R5: `tick_o` is low while `rst_n` is low. After reset the ratio is 4 (configuration 0x20). The first strobe appears in the fourth cycle, counting the cycle in which `rst_n` is released.
- R6: A configuration presented in the same cycle as a strobe governs the next period. A change made inside a period does not alter that period's length.
- R7: The largest word, 0xFF, gives a ratio of 31.875: periods of 31 and 32 cycles adding up to 255 cycles over 8 periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 8 | Ratio word: whole part in bits 7:3, eighths in bits 2:0 |
| tick_o | output | 1 | One-cycle enable strobe, one per output period |

## Verification
The ratio words cover several cases:
- N = 0 at small and large M checks the integer path with no dithering.
- N = 1, N = 4 and N = 7 place one, four and seven long periods in every eight, which separates a wrong carry count from a wrong base length.
- M = 0 with and without eighths confirms that the clamp also discards N.
- 0xFF checks that the period counter has room for M+1 at the top of the range.

A reprogramming in the middle of a long period shows whether the word is taken only at the boundary. The reset run fixes the default length and the position of the first strobe.

// File: rtl/prescale_pkg.sv
package prescale_pkg;
  localparam int INT_W  = 5;
  localparam int FRAC_W = 3;
  localparam int CFG_W  = INT_W + FRAC_W;
  localparam int CNT_W  = INT_W + 1;

  typedef struct packed {
    logic [INT_W-1:0]  whole;
    logic [FRAC_W-1:0] eighths;
  } ratio_t;

  // Split the word; a zero whole part collapses to ratio one.
  function automatic ratio_t decode_cfg(logic [CFG_W-1:0] word);
    ratio_t r;
    r.whole   = word[CFG_W-1:FRAC_W];
    r.eighths = word[FRAC_W-1:0];
    if (r.whole == '0) begin
      r.whole   = INT_W'(1);
      r.eighths = '0;
    end
    return r;
  endfunction

  // Accumulator step: top bit is the carry into an extra cycle.
  function automatic logic [FRAC_W:0] frac_sum(logic [FRAC_W-1:0] acc,
                                               logic [FRAC_W-1:0] add);
    return {1'b0, acc} + {1'b0, add};
  endfunction

  function automatic logic [CNT_W-1:0] period_len(logic [INT_W-1:0] whole,
                                                  logic carry);
    return CNT_W'(whole) + CNT_W'(carry);
  endfunction
endpackage

// File: rtl/prescale_cfg_decode.sv
module prescale_cfg_decode
  import prescale_pkg::*;
(
  input  logic [CFG_W-1:0] cfg,
  output ratio_t           ratio
);
  always_comb ratio = decode_cfg(cfg);
endmodule

// File: rtl/prescale_frac_accum.sv
module prescale_frac_accum
  import prescale_pkg::*;
#(
  parameter logic [FRAC_W-1:0] RESET_ACC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [FRAC_W-1:0] eighths,
  output logic              carry
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  always_comb begin
    sum   = frac_sum(acc_q, eighths);
    carry = sum[FRAC_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= RESET_ACC;
    else if (load) acc_q <= sum[FRAC_W-1:0];
  end

  // R3: the phase only moves at a boundary; a carry wraps it downward.
  assert_acc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(acc_q));
  assert_acc_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && carry) |=> (acc_q < $past(acc_q)));
  assert_acc_climb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !carry) |=> (acc_q >= $past(acc_q)));
endmodule

// File: rtl/prescale_period_counter.sv
module prescale_period_counter
  import prescale_pkg::*;
#(
  parameter logic [CNT_W-1:0] RESET_LEN = CNT_W'(4)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] next_len,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;

  always_comb tick = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= RESET_LEN;
    else if (tick) cnt_q <= next_len;
    else           cnt_q <= cnt_q - CNT_W'(1);
  end

  // R2: the remaining count never reaches zero, and each new length fits the range.
  assert_count_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != '0);
  assert_len_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (next_len != '0 && next_len <= CNT_W'(1 << INT_W)));
endmodule

// File: rtl/frac_prescaler.sv
module frac_prescaler
  import prescale_pkg::*;
#(
  parameter logic [CFG_W-1:0] RESET_CFG = CFG_W'(8'h20)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             tick_o
);
  localparam ratio_t RESET_RATIO = decode_cfg(RESET_CFG);

  ratio_t           ratio;
  logic             extra_cycle;
  logic [CNT_W-1:0] next_len;
  logic             boundary;

  prescale_cfg_decode u_decode (
    .cfg   (cfg_i),
    .ratio (ratio)
  );

  prescale_frac_accum #(
    .RESET_ACC (RESET_RATIO.eighths)
  ) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (boundary),
    .eighths (ratio.eighths),
    .carry   (extra_cycle)
  );

  always_comb next_len = period_len(ratio.whole, extra_cycle);

  prescale_period_counter #(
    .RESET_LEN (CNT_W'(RESET_RATIO.whole))
  ) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .next_len (next_len),
    .tick     (boundary)
  );

  always_comb tick_o = boundary;

  // Watch logic: period length seen at the port against the ratio latched at the last strobe.
  logic [CNT_W-1:0] gap_q;
  logic [INT_W-1:0] m_seen_q;
  logic             long_ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q     <= '0;
      m_seen_q  <= RESET_RATIO.whole;
      long_ok_q <= (RESET_RATIO.eighths != '0);
    end else if (tick_o) begin
      gap_q     <= '0;
      m_seen_q  <= ratio.whole;
      long_ok_q <= (ratio.eighths != '0);
    end else begin
      gap_q     <= gap_q + CNT_W'(1);
    end
  end

  // R2 and R6: each period is M or M+1 of the ratio taken at its start.
  assert_period_fits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> ((gap_q + CNT_W'(1)) == CNT_W'(m_seen_q)) ||
               (long_ok_q && (gap_q == CNT_W'(m_seen_q))));
  assert_no_stretch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_o |-> ((gap_q + CNT_W'(1)) < (CNT_W'(m_seen_q) + CNT_W'(long_ok_q))));
  // R4: a zero whole part keeps the strobe high on every cycle.
  assert_zero_whole_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && cfg_i[CFG_W-1:FRAC_W] == '0) |=> tick_o);
  // R5: no strobe while held in reset.
  always_comb begin
    if (!rst_n) assert_quiet_reset_R5: assert (!tick_o);
  end
endmodule

// File: tb/frac_prescaler_test.sv
module frac_prescaler_test;
  localparam int HALF = 4;
  localparam int NVEC = 10;
  // {cfg, total over 8 periods, shortest, longest}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'h20, 12'd32,  6'd4,  6'd4},
    {8'h21, 12'd33,  6'd4,  6'd5},
    {8'h27, 12'd39,  6'd4,  6'd5},
    {8'h4C, 12'd76,  6'd9,  6'd10},
    {8'h08, 12'd8,   6'd1,  6'd1},
    {8'h0F, 12'd15,  6'd1,  6'd2},
    {8'hF8, 12'd248, 6'd31, 6'd31},
    {8'hFF, 12'd255, 6'd31, 6'd32},
    {8'h05, 12'd8,   6'd1,  6'd1},
    {8'h00, 12'd8,   6'd1,  6'd1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg = 8'h20;
  logic       tick;
  int         n_checks = 0;
  int         n_fail = 0;
  bit         finished = 1'b0;

  always #HALF clk = ~clk;

  frac_prescaler uut (.clk(clk), .rst_n(rst_n), .cfg_i(cfg), .tick_o(tick));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sync_boundary();
    while (!tick) @(negedge clk);
  endtask

  task automatic one_period(output int len);
    len = 0;
    do begin
      @(negedge clk);
      len++;
    end while (!tick);
  endtask

  task automatic eight_periods(output int total, output int lo, output int hi);
    int len;
    total = 0; lo = 1000; hi = 0;
    for (int p = 0; p < 8; p++) begin
      one_period(len);
      total += len;
      if (len < lo) lo = len;
      if (len > hi) hi = len;
    end
  endtask

  initial begin
    int total, lo, hi, len;
    // R5: reset state and default ratio
    repeat (3) @(negedge clk);
    check(tick == 1'b0, "R5 quiet in reset", int'(tick), 0);
    rst_n = 1'b1;
    len = 1;
    while (!tick) begin
      @(negedge clk);
      len++;
    end
    check(len == 4, "R5 first strobe cycle", len, 4);
    eight_periods(total, lo, hi);
    check(total == 32, "R5 default ratio total", total, 32);

    // R1 R2 R3 R4 R7: vector table
    for (int v = 0; v < NVEC; v++) begin
      cfg = VEC[v][31:24];
      sync_boundary();
      eight_periods(total, lo, hi);
      check(total == int'(VEC[v][23:12]), $sformatf("R1 R3 total cfg=%02h", cfg),
            total, int'(VEC[v][23:12]));
      check(lo == int'(VEC[v][11:6]), $sformatf("R2 shortest cfg=%02h", cfg),
            lo, int'(VEC[v][11:6]));
      check(hi == int'(VEC[v][5:0]), $sformatf("R2 longest cfg=%02h", cfg),
            hi, int'(VEC[v][5:0]));
    end

    // R4: zero whole part with eighths set, strobe on every cycle
    cfg = 8'h07;
    sync_boundary();
    total = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (tick) total++;
    end
    check(total == 12, "R4 strobe every cycle", total, 12);

    // R7: top of range, lengths 31 and 32 only
    cfg = 8'hFF;
    sync_boundary();
    eight_periods(total, lo, hi);
    check(total == 255 && hi == 32, "R7 max ratio total", total, 255);

    // R6: change inside a long period does not disturb it
    cfg = 8'hF8;
    sync_boundary();
    len = 0;
    repeat (5) begin
      @(negedge clk);
      len++;
    end
    cfg = 8'h10;
    while (!tick) begin
      @(negedge clk);
      len++;
    end
    check(len == 31, "R6 current period kept", len, 31);
    one_period(len);
    check(len == 2, "R6 new ratio first period", len, 2);
    one_period(len);
    check(len == 2, "R6 new ratio second period", len, 2);

    // R6: word shown only between strobes is ignored
    cfg = 8'h30;
    sync_boundary();
    @(negedge clk);
    cfg = 8'h08;
    @(negedge clk);
    cfg = 8'h30;
    len = 2;
    while (!tick) begin
      @(negedge clk);
      len++;
    end
    check(len == 6, "R6 brief word ignored", len, 6);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(2 * HALF * 200000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule